// File: doc/BRIEF.md
# Prescaled 8-bit timer/counter

The block is an 8-bit up-counter that software loads and reads through a simple write port and a read-back output. Each increment comes from one of two sources: a one-cycle instruction tick supplied by the surrounding core (timer mode), or a free-running external input (counter mode). In counter mode the external input is resynchronised into the block clock domain, and a control input chooses whether rising or falling transitions count. When the counter steps from its all-ones value back to zero, it sets an overflow flag. The flag stays set until software clears it.

A programmable power-of-two prescaler can be placed between the selected source and the counter. The prescaler is shared with a neighbouring supervision path. When it is handed to that path, the counter steps once per source event and the prescaler divides the supervision path's input instead. A software load of the count suppresses counting for the next two instruction ticks. The same load also empties the prescaler.

Top module: `pscl_timer8`

## Requirements
- R1: After reset, the count reads 0x00 and the overflow flag reads 0.
- R2: A write (`wr_en_i` high for one clock) places `wr_data_i` on `count_o` after that clock edge. A write has priority over any increment in the same cycle.
- R3: With `src_ext_i`=0 and `psc_to_wdt_i`=1, the count rises by exactly one for each clock cycle in which `tick_i` is high. This holds for separated pulses and for consecutive high cycles.
- R4: With `src_ext_i`=1, the count rises once per transition of `ext_clk_i`: rising transitions when `edge_fall_i`=0 and falling transitions when `edge_fall_i`=1. The opposite transition and `tick_i` have no effect on the count. The input passes through a two-stage synchroniser and an edge detector, so the count changes on the third clock edge after the new level is first sampled.
- R5: After a write, any count event is discarded until two `tick_i` pulses have occurred. The first event after the second such pulse counts. This applies in both source modes.
- R6: With `psc_to_wdt_i`=0, the counter rises once for every 2^(`psc_sel_i`+1) accepted source events. Encoding: 0 gives /2, 1 gives /4, and so on up to 7, which gives /256.
- R7: A write clears the prescaler's internal count, so a full new ratio of events is needed before the next increment.
- R8: An increment from 0xFF gives 0x00 and sets `ovf_flag_o`.
- R9: `ovf_flag_o` stays set until a cycle with `ovf_clr_i`=1 clears it. If a clear and a wrap fall in the same cycle, the flag stays set.
- R10: With `psc_to_wdt_i`=1, `wdt_pulse_o` is high during the `wdt_src_i` pulse that completes every 2^(`psc_sel_i`+1) pulses. With `psc_to_wdt_i`=0, `wdt_pulse_o` follows `wdt_src_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle instruction tick |
| ext_clk_i | input | 1 | External count input (asynchronous) |
| src_ext_i | input | 1 | 0: count ticks, 1: count external edges |
| edge_fall_i | input | 1 | 0: rising edges, 1: falling edges |
| psc_to_wdt_i | input | 1 | 1: prescaler serves supervision path, counter runs 1:1 |
| psc_sel_i | input | 3 | Prescaler ratio select, /2^(sel+1) |
| wr_en_i | input | 1 | Count register write strobe |
| wr_data_i | input | 8 | Count register write value |
| count_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Overflow flag clear |
| wdt_src_i | input | 1 | Supervision path input pulses |
| wdt_pulse_o | output | 1 | Supervision path output pulses |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a wrap. Reaching it requires the count to be loaded to 0xFF, the two-tick suppression to be used up, and an existing flag left standing. The stimulus first causes one overflow so that the flag is set. It then reloads 0xFF, spends two ticks, and drives the final tick and the clear on the same falling edge. A second hard case is the prescaler reset on a write. This is reached by leaving the prescaler part-way through a /8 ratio, writing, and then showing that seven more accepted events do not yet step the counter.

// File: rtl/pscl_timer8_pkg.sv
package pscl_timer8_pkg;
  // number of instruction ticks for which counting stays blocked after a load
  localparam int unsigned INHIBIT_TICKS = 2;
  // depth of the external input synchroniser
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    SRC_TICK = 1'b0,
    SRC_EXT  = 1'b1
  } clk_src_e;
endpackage

// File: rtl/pscl_edge_sync.sv
module pscl_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  // q[STAGES-1:0] form the synchroniser, q[STAGES] holds the previous level
  logic [STAGES:0] q_q;
  logic [STAGES:0] q_d;
  logic            lvl_now;
  logic            lvl_prev;

  always_comb begin
    q_d = {q_q[STAGES-1:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign lvl_now  = q_q[STAGES-1];
  assign lvl_prev = q_q[STAGES];
  assign edge_o   = fall_sel_i ? (~lvl_now & lvl_prev) : (lvl_now & ~lvl_prev);
endmodule

// File: rtl/pscl_prescaler.sv
module pscl_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  localparam int unsigned PW = 1 << SEL_W;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic [PW-1:0] mask;

  // mask selects the low (sel+1) bits that must all be one for a pulse
  for (genvar i = 0; i < PW; i++) begin : g_mask
    assign mask[i] = (i <= int'(sel_i));
  end

  assign pulse_o = evt_i & (&(cnt_q | ~mask));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (evt_i) cnt_d = cnt_q + {{(PW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pscl_inhibit.sv
module pscl_inhibit #(
  parameter int unsigned N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic tick_i,
  output logic block_o
);
  localparam int unsigned IW = $clog2(N + 1);

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] cnt_d;

  assign block_o = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                cnt_d = IW'(N);
    else if (tick_i && block_o) cnt_d = cnt_q - {{(IW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pscl_timer8.sv
module pscl_timer8
  import pscl_timer8_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PSC_SEL_W = 3,
  parameter int unsigned INHIBIT_N = INHIBIT_TICKS,
  parameter int unsigned SYNC_N    = SYNC_DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 ext_clk_i,
  input  logic                 src_ext_i,
  input  logic                 edge_fall_i,
  input  logic                 psc_to_wdt_i,
  input  logic [PSC_SEL_W-1:0] psc_sel_i,
  input  logic                 wr_en_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  output logic [CNT_W-1:0]     count_o,
  output logic                 ovf_flag_o,
  input  logic                 ovf_clr_i,
  input  logic                 wdt_src_i,
  output logic                 wdt_pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  clk_src_e   src_sel;
  logic       ext_edge;
  logic       blocked;
  logic       src_evt;
  logic       gated_evt;
  logic       psc_in;
  logic       psc_out;
  logic       cnt_evt;
  logic       inc_en;
  logic       wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic       flag_q;
  logic       flag_d;

  assign src_sel = clk_src_e'(src_ext_i);

  pscl_edge_sync #(.STAGES(SYNC_N)) u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .din_i     (ext_clk_i),
    .fall_sel_i(edge_fall_i),
    .edge_o    (ext_edge)
  );

  pscl_inhibit #(.N(INHIBIT_N)) u_inh (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (wr_en_i),
    .tick_i (tick_i),
    .block_o(blocked)
  );

  assign src_evt   = (src_sel == SRC_EXT) ? ext_edge : tick_i;
  assign gated_evt = src_evt & ~blocked;
  assign psc_in    = psc_to_wdt_i ? wdt_src_i : gated_evt;

  pscl_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (wr_en_i),
    .evt_i  (psc_in),
    .sel_i  (psc_sel_i),
    .pulse_o(psc_out)
  );

  assign cnt_evt     = psc_to_wdt_i ? gated_evt : psc_out;
  assign wdt_pulse_o = psc_to_wdt_i ? psc_out : wdt_src_i;

  // counter next state: a load wins over an increment
  always_comb begin
    inc_en = cnt_evt & ~wr_en_i;
    wrap   = inc_en & (cnt_q == CNT_MAX);
    cnt_d  = cnt_q;
    if (wr_en_i)     cnt_d = wr_data_i;
    else if (inc_en) cnt_d = cnt_q + CNT_ONE;
    flag_d = wrap | (flag_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign count_o    = cnt_q;
  assign ovf_flag_o = flag_q;
endmodule

// File: rtl/pscl_timer8_chk.sv
module pscl_timer8_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_flag_o,
  input logic             ovf_clr_i,
  input logic             psc_to_wdt_i,
  input logic             wdt_src_i,
  input logic             wdt_pulse_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2: a load appears on the next edge
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (count_o == $past(wr_data_i)));

  // R3: without a load the count holds or steps by one
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

  // R5: the cycle right after a load cannot count
  p_hold_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i ##1 !wr_en_i) |=> (count_o == $past(count_o)));

  // R8: stepping from all-ones to zero raises the flag
  p_wrap_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && count_o == CMAX) |=> (count_o != '0 || ovf_flag_o));

  // R9: the flag only drops on a clear
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

  // R10: with the prescaler on the counter side the supervision path is 1:1
  p_wdt_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !psc_to_wdt_i |-> (wdt_pulse_o == wdt_src_i));
endmodule

bind pscl_timer8 pscl_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .count_o     (count_o),
  .ovf_flag_o  (ovf_flag_o),
  .ovf_clr_i   (ovf_clr_i),
  .psc_to_wdt_i(psc_to_wdt_i),
  .wdt_src_i   (wdt_src_i),
  .wdt_pulse_o (wdt_pulse_o)
);

// File: tb/pscl_timer8_bench.sv
`timescale 1ns/1ps
module pscl_timer8_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, ext_clk_i, src_ext_i, edge_fall_i, psc_to_wdt_i;
  logic [2:0] psc_sel_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] count_o;
  logic       ovf_flag_o, ovf_clr_i, wdt_src_i, wdt_pulse_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pscl_timer8 u_pscl_timer8 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_clk_i(ext_clk_i),
    .src_ext_i(src_ext_i), .edge_fall_i(edge_fall_i), .psc_to_wdt_i(psc_to_wdt_i),
    .psc_sel_i(psc_sel_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .count_o(count_o), .ovf_flag_o(ovf_flag_o), .ovf_clr_i(ovf_clr_i),
    .wdt_src_i(wdt_src_i), .wdt_pulse_o(wdt_pulse_o)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_write(logic [7:0] v);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = v;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic ext_to(logic v);
    @(negedge clk) ext_clk_i = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 count", count_o, 0);
    check("R1 flag", ovf_flag_o, 0);
  endtask

  task automatic t_write_priority;
    psc_to_wdt_i = 1'b1; src_ext_i = 1'b0;
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h5A; tick_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; tick_i = 1'b0;
    check("R2 load wins", count_o, 8'h5A);
  endtask

  task automatic t_timer_inhibit;
    do_write(8'h20);
    ticks(1); check("R5 first tick blocked", count_o, 8'h20);
    ticks(1); check("R5 second tick blocked", count_o, 8'h20);
    ticks(1); check("R5 third tick counts", count_o, 8'h21);
    ticks(2); check("R3 separate ticks", count_o, 8'h23);
    @(negedge clk) tick_i = 1'b1;
    repeat (3) @(negedge clk);
    tick_i = 1'b0;
    check("R3 held tick", count_o, 8'h26);
  endtask

  task automatic t_ext_edges;
    src_ext_i = 1'b1; edge_fall_i = 1'b0;
    do_write(8'h40);
    ext_to(1'b1); check("R5 ext edge blocked", count_o, 8'h40);
    ext_to(1'b0);
    ticks(2); check("R4 tick ignored", count_o, 8'h40);
    // latency: change at negedge, count updated on third posedge
    @(negedge clk) ext_clk_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 sync latency before", count_o, 8'h40);
    @(negedge clk);
    check("R4 rising counted", count_o, 8'h41);
    ext_to(1'b0); check("R4 falling ignored", count_o, 8'h41);
    ext_to(1'b1); check("R4 second rise", count_o, 8'h42);
    edge_fall_i = 1'b1;
    ext_to(1'b0); check("R4 falling counted", count_o, 8'h43);
    ext_to(1'b1); check("R4 rising ignored", count_o, 8'h43);
    src_ext_i = 1'b0;
  endtask

  task automatic t_prescale;
    psc_to_wdt_i = 1'b0; psc_sel_i = 3'd1;
    do_write(8'h00); ticks(2);
    ticks(3); check("R6 /4 not yet", count_o, 8'h00);
    ticks(1); check("R6 /4 step", count_o, 8'h01);
    ticks(4); check("R6 /4 second step", count_o, 8'h02);
    psc_sel_i = 3'd2;
    ticks(5);
    do_write(8'h10); ticks(2);
    ticks(7); check("R7 prescaler cleared", count_o, 8'h10);
    ticks(1); check("R7 full ratio step", count_o, 8'h11);
    psc_to_wdt_i = 1'b1;
  endtask

  task automatic t_overflow;
    do_write(8'hFE); ticks(2);
    ticks(1); check("R8 at max", count_o, 8'hFF);
    check("R8 flag clear before wrap", ovf_flag_o, 0);
    ticks(1); check("R8 wrap to zero", count_o, 8'h00);
    check("R8 flag set", ovf_flag_o, 1);
    repeat (4) @(negedge clk);
    check("R9 flag sticky", ovf_flag_o, 1);
    @(negedge clk) ovf_clr_i = 1'b1;
    @(negedge clk) ovf_clr_i = 1'b0;
    check("R9 flag cleared", ovf_flag_o, 0);
    do_write(8'hFF); ticks(2); ticks(1);
    check("R9 flag set again", ovf_flag_o, 1);
    do_write(8'hFF); ticks(2);
    @(negedge clk); tick_i = 1'b1; ovf_clr_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; ovf_clr_i = 1'b0;
    check("R9 set beats clear", ovf_flag_o, 1);
    check("R9 count wrapped", count_o, 8'h00);
  endtask

  task automatic t_wdt;
    psc_to_wdt_i = 1'b1; psc_sel_i = 3'd0;
    do_write(8'h00);
    @(negedge clk) wdt_src_i = 1'b1; #1;
    check("R10 first pulse divided away", wdt_pulse_o, 0);
    @(negedge clk) wdt_src_i = 1'b0;
    @(negedge clk) wdt_src_i = 1'b1; #1;
    check("R10 second pulse passes", wdt_pulse_o, 1);
    @(negedge clk) wdt_src_i = 1'b0;
    psc_to_wdt_i = 1'b0;
    @(negedge clk) wdt_src_i = 1'b1; #1;
    check("R10 bypass high", wdt_pulse_o, 1);
    @(negedge clk) wdt_src_i = 1'b0; #1;
    check("R10 bypass low", wdt_pulse_o, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 0; ext_clk_i = 0; src_ext_i = 0; edge_fall_i = 0;
    psc_to_wdt_i = 1; psc_sel_i = 0; wr_en_i = 0; wr_data_i = 0;
    ovf_clr_i = 0; wdt_src_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_write_priority;
    t_timer_inhibit;
    t_ext_edges;
    t_prescale;
    t_overflow;
    t_wdt;
    summary;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary;
  end
endmodule